// File: doc/BRIEF.md
# Sixteen-Channel Serial DAC Chain Loader

This block holds one output code per channel for a bank of serial DACs wired as a daisy chain, and moves all of them into the converters in one operation. A host writes codes through a 16-bit word register port. Setting the start bit in the control word makes the block copy every code into a private snapshot. It then clocks one 24-bit frame per DAC down the chain and, once the last bit has gone out, pulses a single shared load strobe so that every analogue output changes at the same instant.

Codes are 18 bits wide. Two host layouts are offered: a wide layout that spends two words on each channel, and a 16-bit compatibility layout that gives one word per channel and drops the two lowest code bits. Codes may be written as straight binary or two's complement. The converters always receive offset binary. A zero-all command drives every output to mid-scale, which is zero volts, without touching the stored codes. The same zero-volt load runs by itself after reset.

Top module: `dac_chain_loader`

## Requirements
- R1: With control bit 3 at 0 (wide layout), channel k (0..15) owns word 8+2k, which holds code bits 15:0, and word 9+2k, which holds code bits 17:16 in bits 1:0. All other bits of that second word read as zero.
- R2: With control bit 3 at 1 (compatibility layout), channel k owns word 8+k, which holds code bits 17:2. A write clears code bits 1:0, and a read returns code bits 17:2.
- R3: A transfer shifts 16 frames of 24 bits each, MSB first. The 18-bit code sits in frame bits 23:6 and bits 5:0 are zero. The frame for channel 16 goes out first and channel 1 goes out last. Data changes while the serial clock is low and is held through the high phase.
- R4: The load strobe goes low for exactly two clock cycles after the last bit, with the serial clock held low. Busy then drops and the start bit (control bit 0) reads 0 again.
- R5: Busy (the port, and control bit 7) reads 1 within two cycles of an accepted start and stays 1 until the strobe ends. While busy is 0, the strobe stays high and the serial clock stays low.
- R6: With control bit 2 at 1 (two's complement), each code goes out with bit 17 inverted. With bit 2 at 0, each code goes out unchanged.
- R7: Writing control bit 1 (zero-all) runs a transfer in which every frame carries the code 0x20000. The stored codes are left as they are, and the bit clears itself at the end. If the start bit is written in the same word, zero-all takes priority.
- R8: Reset clears every channel register and the control word, then starts a zero-volt transfer of its own accord.
- R9: Channel writes made while busy are stored and read back, but the transfer in progress sends the codes captured when it started.
- R10: The start and zero-all bits have no effect if written while a transfer is pending or running. The start bit also has no effect if control bit 4 (playback owner) is 1 in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe for one cycle |
| host_addr | input | 6 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| ser_clk_o | output | 1 | Serial clock to the DAC chain |
| ser_data_o | output | 1 | Serial data into the first DAC |
| ser_load_n_o | output | 1 | Shared active-low load strobe |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions watch the serial timing on every cycle. They check that data holds still while the clock is high, that the clock never stays high for two cycles, that the strobe is two cycles wide with the clock parked low, and that the lines stay quiet and the busy flag drops only at the end of a strobe. The bench scenarios are the only place where content is checked: the frame order across the chain, the code layouts, the two's-complement inversion, the mid-scale code for zero-all and after reset, the snapshot against late writes, and the start requests that are ignored.

// File: rtl/dcl_pkg.sv
// Shared constants and types for the DAC chain loader.
// Assumes: 18-bit converter codes, 16-bit host words, control word at address 0.
package dcl_pkg;
    localparam int CODE_W   = 18;
    localparam int DW       = 16;
    localparam int HI_BITS  = CODE_W - DW;
    localparam int CTL_ADDR = 0;
    localparam int CH_BASE  = 8;

    // control word bit positions
    localparam int CTL_ARM    = 0;
    localparam int CTL_ZERO   = 1;
    localparam int CTL_TWOS   = 2;
    localparam int CTL_COMPAT = 3;
    localparam int CTL_PLAY   = 4;
    localparam int CTL_BUSY   = 7;

    // offset-binary mid-scale, the zero-volt code
    localparam logic [CODE_W-1:0] ZERO_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_LOAD  = 2'd2
    } sh_state_t;
endpackage

// File: rtl/dcl_regs.sv
// Host register file: control word plus per-channel code storage.
// Decodes the wide (two words per channel) or compatibility (one word)
// layout and holds the self-clearing start and zero-all requests.
// Assumes: 8 + 2*NCH fits in the address space.
module dcl_regs
    import dcl_pkg::*;
#(
    parameter int NCH = 16,
    parameter int AW  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    input  logic                       busy,
    input  logic                       finish,
    output logic [DW-1:0]              rdata,
    output logic [NCH-1:0][CODE_W-1:0] codes,
    output logic                       arm_req,
    output logic                       zero_req,
    output logic                       twos_mode,
    output logic                       compat_mode
);
    logic [NCH-1:0][CODE_W-1:0] code_q;
    logic arm_q, zero_q, twos_q, compat_q, play_q;
    logic engaged;
    logic ctl_hit;

    assign engaged = busy | arm_q | zero_q;
    assign ctl_hit = we && (addr == AW'(CTL_ADDR));

    // control word: mode bits, and request bits that clear at transfer end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q    <= 1'b0;
            zero_q   <= 1'b1;
            twos_q   <= 1'b0;
            compat_q <= 1'b0;
            play_q   <= 1'b0;
        end else begin
            if (finish) begin
                arm_q  <= 1'b0;
                zero_q <= 1'b0;
            end
            if (ctl_hit) begin
                twos_q   <= wdata[CTL_TWOS];
                compat_q <= wdata[CTL_COMPAT];
                play_q   <= wdata[CTL_PLAY];
                if (!engaged) begin
                    if (wdata[CTL_ZERO])
                        zero_q <= 1'b1;
                    if (wdata[CTL_ARM] && !wdata[CTL_PLAY])
                        arm_q <= 1'b1;
                end
            end
        end
    end

    // channel code storage, written through the active layout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (we) begin
            for (int k = 0; k < NCH; k++) begin
                if (compat_q) begin
                    if (addr == AW'(CH_BASE + k))
                        code_q[k] <= {wdata, {HI_BITS{1'b0}}};
                end else begin
                    if (addr == AW'(CH_BASE + 2*k))
                        code_q[k][DW-1:0] <= wdata;
                    if (addr == AW'(CH_BASE + 2*k + 1))
                        code_q[k][CODE_W-1:DW] <= wdata[HI_BITS-1:0];
                end
            end
        end
    end

    // read mux over control word and channel words
    always_comb begin
        rdata = '0;
        if (addr == AW'(CTL_ADDR)) begin
            rdata[CTL_ARM]    = arm_q;
            rdata[CTL_ZERO]   = zero_q;
            rdata[CTL_TWOS]   = twos_q;
            rdata[CTL_COMPAT] = compat_q;
            rdata[CTL_PLAY]   = play_q;
            rdata[CTL_BUSY]   = busy;
        end
        for (int k = 0; k < NCH; k++) begin
            if (compat_q) begin
                if (addr == AW'(CH_BASE + k))
                    rdata = code_q[k][CODE_W-1:HI_BITS];
            end else begin
                if (addr == AW'(CH_BASE + 2*k))
                    rdata = code_q[k][DW-1:0];
                if (addr == AW'(CH_BASE + 2*k + 1))
                    rdata = {{(DW-HI_BITS){1'b0}}, code_q[k][CODE_W-1:DW]};
            end
        end
    end

    assign codes       = code_q;
    assign arm_req     = arm_q;
    assign zero_req    = zero_q;
    assign twos_mode   = twos_q;
    assign compat_mode = compat_q;
endmodule

// File: rtl/dcl_fmt.sv
// Converts stored codes to the offset-binary form the converters expect.
// In two's-complement mode only the code MSB differs, so it is inverted.
// Assumes: purely combinational, one instance serves all channels.
module dcl_fmt
    import dcl_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                       twos_mode,
    input  logic [NCH-1:0][CODE_W-1:0] codes_in,
    output logic [NCH-1:0][CODE_W-1:0] codes_out
);
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        // flip sign bit per channel when input is two's complement
        assign codes_out[k] = {codes_in[k][CODE_W-1] ^ twos_mode,
                               codes_in[k][CODE_W-2:0]};
    end
endmodule

// File: rtl/dcl_shifter.sv
// Chain serializer: snapshots all codes on start, sends one left-justified
// frame per DAC (last channel first), then drives the shared load strobe.
// Assumes: FRAME_W > CODE_W; each serial bit lasts two clock cycles.
module dcl_shifter
    import dcl_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int FRAME_W  = 24,
    parameter int LOAD_CYC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       zero_sel,
    input  logic [NCH-1:0][CODE_W-1:0] codes,
    output logic                       ser_clk,
    output logic                       ser_data,
    output logic                       load_n,
    output logic                       busy,
    output logic                       finish
);
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int BIT_W = $clog2(FRAME_W);
    localparam int LC_W  = $clog2(LOAD_CYC + 1);

    sh_state_t                  st;
    logic [CH_W-1:0]            ch_q;
    logic [BIT_W-1:0]           bit_q;
    logic                       ph_q;
    logic [LC_W-1:0]            lc_q;
    logic [NCH-1:0][CODE_W-1:0] snap;
    logic [FRAME_W-1:0]         cur_frame;

    // capture the codes (or mid-scale) at the moment a transfer starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (st == SH_IDLE && start) begin
            for (int k = 0; k < NCH; k++)
                snap[k] <= zero_sel ? ZERO_CODE : codes[k];
        end
    end

    // sequencer: two clocks per bit, channel countdown, then load pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SH_IDLE;
            ch_q  <= '0;
            bit_q <= '0;
            ph_q  <= 1'b0;
            lc_q  <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        st    <= SH_SHIFT;
                        ch_q  <= CH_W'(NCH - 1);
                        bit_q <= BIT_W'(FRAME_W - 1);
                        ph_q  <= 1'b0;
                    end
                end
                SH_SHIFT: begin
                    if (!ph_q) begin
                        ph_q <= 1'b1;
                    end else begin
                        ph_q <= 1'b0;
                        if (bit_q == '0) begin
                            if (ch_q == '0) begin
                                st   <= SH_LOAD;
                                lc_q <= '0;
                            end else begin
                                ch_q  <= ch_q - 1'b1;
                                bit_q <= BIT_W'(FRAME_W - 1);
                            end
                        end else begin
                            bit_q <= bit_q - 1'b1;
                        end
                    end
                end
                SH_LOAD: begin
                    if (lc_q == LC_W'(LOAD_CYC - 1))
                        st <= SH_IDLE;
                    else
                        lc_q <= lc_q + 1'b1;
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    // frame under transmission: code left-justified, pad bits zero
    always_comb begin
        cur_frame = '0;
        cur_frame[FRAME_W-1 -: CODE_W] = snap[ch_q];
    end

    assign busy     = (st != SH_IDLE);
    assign ser_clk  = (st == SH_SHIFT) && ph_q;
    assign ser_data = (st == SH_SHIFT) && cur_frame[bit_q];
    assign load_n   = (st != SH_LOAD);
    assign finish   = (st == SH_LOAD) && (lc_q == LC_W'(LOAD_CYC - 1));
endmodule

// File: rtl/dac_chain_loader.sv
// Top level: host register file, format stage and chain serializer.
// A pending start or zero-all request launches a transfer when idle.
// Assumes: synchronous active-low reset; host writes last one cycle.
module dac_chain_loader
    import dcl_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int AW       = 6,
    parameter int FRAME_W  = 24,
    parameter int LOAD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    output logic          ser_clk_o,
    output logic          ser_data_o,
    output logic          ser_load_n_o,
    output logic          busy_o
);
    logic [NCH-1:0][CODE_W-1:0] raw_codes;
    logic [NCH-1:0][CODE_W-1:0] dac_codes;
    logic arm_req, zero_req, twos_mode, compat_mode;
    logic sh_busy, sh_finish, start;

    // launch when idle and any request is pending
    assign start = !sh_busy && (arm_req || zero_req);

    dcl_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .busy(sh_busy), .finish(sh_finish),
        .rdata(host_rdata), .codes(raw_codes),
        .arm_req(arm_req), .zero_req(zero_req),
        .twos_mode(twos_mode), .compat_mode(compat_mode)
    );

    dcl_fmt #(.NCH(NCH)) u_fmt (
        .twos_mode(twos_mode), .codes_in(raw_codes), .codes_out(dac_codes)
    );

    dcl_shifter #(.NCH(NCH), .FRAME_W(FRAME_W), .LOAD_CYC(LOAD_CYC)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(start), .zero_sel(zero_req), .codes(dac_codes),
        .ser_clk(ser_clk_o), .ser_data(ser_data_o),
        .load_n(ser_load_n_o), .busy(sh_busy), .finish(sh_finish)
    );

    assign busy_o = sh_busy;

    // compat_mode only shapes the register decode inside u_regs
    logic unused_ok;
    assign unused_ok = compat_mode;
endmodule

// File: rtl/dcl_checker.sv
// Cycle-level protocol checks on the serial side of the loader.
// Assumes: bound to dac_chain_loader; checks only its ports.
module dcl_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sdata,
    input logic load_n,
    input logic busy
);
    // R3: data is held through the clock high phase
    a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdata));

    // R3: the serial clock is never high for two cycles in a row
    a_r3_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

    // R4: the strobe is low for a second cycle after it falls
    a_r4_strobe_second: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_n) |=> !load_n);

    // R4: the strobe is high again after two low cycles
    a_r4_strobe_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && $past(!load_n)) |=> load_n);

    // R4: the clock is parked low while the strobe is low, inside a transfer
    a_r4_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> (!sclk && busy));

    // R5: the outputs stay quiet while idle
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (load_n && !sclk));

    // R5: busy drops only right after a strobe cycle
    a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!load_n));
endmodule

bind dac_chain_loader dcl_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .sclk(ser_clk_o), .sdata(ser_data_o),
    .load_n(ser_load_n_o), .busy(busy_o)
);

// File: tb/sim_dac_chain_loader.sv
module sim_dac_chain_loader;
    localparam int NCH = 16;
    localparam int FW  = 24;
    localparam int NB  = NCH * FW;
    localparam logic [17:0] MID = 18'h20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [5:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic ser_clk_o, ser_data_o, ser_load_n_o, busy_o;

    dac_chain_loader u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ser_clk_o(ser_clk_o), .ser_data_o(ser_data_o),
        .ser_load_n_o(ser_load_n_o), .busy_o(busy_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done_all = 1'b0;

    // serial capture
    logic [NB-1:0] rx = '0;
    int rx_cnt = 0;
    int rx_at_load = -1;
    int lo_cnt = 0;

    always @(posedge ser_clk_o) begin
        rx = {rx[NB-2:0], ser_data_o};
        rx_cnt++;
    end
    always @(negedge ser_load_n_o) rx_at_load = rx_cnt;
    always @(negedge clk) if (rst_n && !ser_load_n_o) lo_cnt++;

    // bench model
    logic [17:0] m_code [NCH];
    bit m_twos = 1'b0;
    bit m_compat = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl_word(input bit arm, input bit zero, input bit play);
        return {11'b0, play, m_compat, m_twos, zero, arm};
    endfunction

    function automatic logic [17:0] exp_code(input int c, input bit zero);
        if (zero) return MID;
        return m_twos ? (m_code[c] ^ MID) : m_code[c];
    endfunction

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic put_code(input int c, input logic [17:0] code);
        if (m_compat) begin
            wr(6'(8 + c), code[17:2]);
            m_code[c] = {code[17:2], 2'b00};
        end else begin
            wr(6'(8 + 2*c), code[15:0]);
            wr(6'(9 + 2*c), {14'b0, code[17:16]});
            m_code[c] = code;
        end
    endtask

    task automatic clear_rx();
        rx_cnt = 0; rx_at_load = -1; lo_cnt = 0;
    endtask

    task automatic wait_xfer(input string req);
        int t = 0;
        while (!busy_o && t < 50) begin @(negedge clk); t++; end
        chk(busy_o, {req, " R5 busy raised"}, busy_o, 1);
        while (busy_o && t < 4000) begin @(negedge clk); t++; end
        chk(!busy_o, {req, " R5 busy dropped"}, busy_o, 0);
    endtask

    task automatic check_frames(input bit zero, input string req);
        logic [15:0] v;
        chk(rx_cnt == NB, {req, " R3 bit count"}, rx_cnt, NB);
        chk(rx_at_load == NB, {req, " R4 strobe after last bit"}, rx_at_load, NB);
        chk(lo_cnt == 2, {req, " R4 strobe width"}, lo_cnt, 2);
        for (int c = 0; c < NCH; c++) begin
            logic [23:0] f;
            f = rx[c*FW +: FW];
            chk(f == {exp_code(c, zero), 6'b0}, {req, " R3 frame"}, f, {exp_code(c, zero), 6'b0});
        end
        rd(6'd0, v);
        chk(v[1:0] == 2'b00, {req, " R4 R7 request bits clear"}, v[1:0], 0);
    endtask

    task automatic xfer(input bit zero, input string req);
        clear_rx();
        wr(6'd0, ctl_word(1'b1, zero, 1'b0));
        wait_xfer(req);
        check_frames(zero, req);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4711));
        for (int c = 0; c < NCH; c++) m_code[c] = '0;

        // reset state
        repeat (4) @(negedge clk);
        chk(!busy_o && ser_load_n_o && !ser_clk_o, "R5 R8 idle in reset",
            {busy_o, ser_load_n_o, ser_clk_o}, 3'b010);
        rst_n = 1'b1;
        wait_xfer("R8 auto zero");
        check_frames(1'b1, "R8 auto zero");
        rd(6'd8, v);  chk(v == 0, "R8 ch1 low cleared", v, 0);
        rd(6'd39, v); chk(v == 0, "R8 ch16 high cleared", v, 0);
        rd(6'd0, v);  chk(v == 0, "R8 control cleared", v, 0);

        // wide layout
        wr(6'd8, 16'hFFFF); wr(6'd9, 16'hFFFF);
        m_code[0] = 18'h3FFFF;
        rd(6'd9, v); chk(v == 16'h0003, "R1 high word masks", v, 16'h0003);
        rd(6'd8, v); chk(v == 16'hFFFF, "R1 low word", v, 16'hFFFF);
        put_code(15, 18'h00001);
        for (int c = 1; c < 15; c++) put_code(c, 18'($urandom));
        xfer(1'b0, "R3 straight");

        // two's complement
        m_twos = 1'b1;
        wr(6'd0, ctl_word(1'b0, 1'b0, 1'b0));
        xfer(1'b0, "R6 twos");

        // random mix of modes and codes
        for (int it = 0; it < 6; it++) begin
            m_twos = $urandom & 1;
            m_compat = $urandom & 1;
            wr(6'd0, ctl_word(1'b0, 1'b0, 1'b0));
            for (int c = 0; c < NCH; c++) put_code(c, 18'($urandom));
            xfer(1'b0, m_compat ? "R2 R6 random compat" : "R1 R6 random wide");
        end

        // compatibility layout readback
        m_compat = 1'b1; m_twos = 1'b0;
        wr(6'd0, ctl_word(1'b0, 1'b0, 1'b0));
        put_code(3, 18'h2AF37);
        rd(6'd11, v); chk(v == 16'hABCD, "R2 compat readback", v, 16'hABCD);
        xfer(1'b0, "R2 compat frames");

        // snapshot and ignored requests while busy
        m_compat = 1'b0;
        wr(6'd0, ctl_word(1'b0, 1'b0, 1'b0));
        for (int c = 0; c < NCH; c++) put_code(c, 18'($urandom));
        clear_rx();
        wr(6'd0, ctl_word(1'b1, 1'b0, 1'b0));
        repeat (20) @(negedge clk);
        rd(6'd0, v); chk(v[7] == 1'b1, "R5 busy bit in control", v[7], 1);
        wr(6'd18, 16'h1234);
        wr(6'd0, ctl_word(1'b1, 1'b1, 1'b0));
        wait_xfer("R9 snapshot");
        check_frames(1'b0, "R9 snapshot");
        rd(6'd18, v); chk(v == 16'h1234, "R9 late write stored", v, 16'h1234);
        m_code[5][15:0] = 16'h1234;
        repeat (30) @(negedge clk);
        chk(!busy_o && rx_cnt == NB, "R10 busy-time requests ignored", rx_cnt, NB);

        // zero-all with start in same word, stored codes kept
        xfer(1'b1, "R7 zero all");
        rd(6'd18, v); chk(v == 16'h1234, "R7 codes kept", v, 16'h1234);

        // start with playback owner set
        clear_rx();
        wr(6'd0, ctl_word(1'b1, 1'b0, 1'b1));
        repeat (40) @(negedge clk);
        rd(6'd0, v);
        chk(!busy_o && rx_cnt == 0 && v[0] == 1'b0, "R10 playback blocks start", rx_cnt, 0);
        wr(6'd0, ctl_word(1'b0, 1'b0, 1'b0));

        // normal transfer afterwards
        put_code(7, 18'h20000);
        xfer(1'b0, "R3 final");

        done_all = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(100000 * 20);
        if (!done_all) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule